// File: doc/BRIEF.md
# Per-Core Thermal Test Window Controller

This controller sits beside one core under multi-temperature test and chooses, every clock cycle, whether that core applies test patterns, heats itself with high-power patterns, cools by applying nothing, waits for the shared test access resource, or has finished. Its inputs are the core's present temperature estimate, a set of programmed limits (upper bound, lower bound, resume temperature after cooling, power threshold), the mean power of the test cycles still to come, and a grant from an outside arbiter.

The limits and the number of test cycles are captured by a load strobe. The controller asks for the access resource only while it waits for its turn. It holds the resource while it tests or heats, and it gives the resource up as soon as the temperature leaves the window. How far heating goes depends on the power of the coming tests. If those tests are power-hungry, heating stops at the lower bound because the tests will warm the core further. If they are not, heating continues to the centre of the window.

Top module: `thermal_window_ctrl`

## Requirements
- R1: After reset, state_o is DONE (encoding 0), and req_o and hold_o are both low.
- R2: A cycle with load_i high captures the limits, the threshold and count_i. One cycle later state_o is WAIT (1), or DONE (0) if count_i is zero. This applies from any state.
- R3: In WAIT, req_o is high and hold_o is low. Without grant_i the state stays WAIT. With grant_i the next state is COOL (4) if temp_i is above the upper bound, HEAT (3) if temp_i is below the lower bound, and TEST (2) otherwise.
- R4: In TEST, a temp_i above the upper bound moves the state to COOL on the next edge, and hold_o falls.
- R5: In TEST, a temp_i below the lower bound moves the state to WAIT on the next edge. This drops hold_o and raises req_o.
- R6: In HEAT, when next_pwr_i is greater than the captured threshold, heating ends with a move to TEST once temp_i is at or above the lower bound.
- R7: In HEAT, when next_pwr_i is at or below the threshold, heating ends only once temp_i reaches the midpoint. The midpoint is (lower + upper) >> 1, computed without overflow and captured at load.
- R8: In HEAT, a temp_i above the upper bound moves the state to COOL. This check takes priority over the end of heating.
- R9: In COOL, req_o and hold_o are low. The state stays COOL until temp_i is below the resume temperature, then moves to WAIT.
- R10: Each TEST cycle with temp_i inside the window uses up one test cycle. After the last one the state becomes DONE. DONE drives neither req_o nor hold_o, and it ignores grant_i until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture limits and test cycle count |
| upper_i | input | 10 | Upper temperature bound |
| lower_i | input | 10 | Lower temperature bound |
| resume_i | input | 10 | Temperature below which cooling ends |
| thr_pwr_i | input | 8 | Power threshold that selects the heating target |
| count_i | input | 12 | Number of test cycles to apply |
| temp_i | input | 10 | Current temperature estimate of the core |
| next_pwr_i | input | 8 | Mean power of the coming test cycles |
| grant_i | input | 1 | Grant of the shared access resource |
| state_o | output | 3 | Current state: DONE 0, WAIT 1, TEST 2, HEAT 3, COOL 4 |
| req_o | output | 1 | Request for the access resource |
| hold_o | output | 1 | Access resource in use (testing or heating) |

## Verification
The bench targets the following corner cases, and the faults each one exposes:
- **Heating target on both sides of the power threshold, including equality.** A design with the comparison inverted, or with `>=` in place of `>`, would hand over to test at the lower bound when it should keep heating toward the midpoint.
- **Midpoint near the top of the temperature range.** A midpoint sum that overflows would wrap to a low value and end heating far too early.
- **Cooling held at exactly the resume temperature.** An off-by-one here would hand the core back while it is still too hot.
- **A core that leaves the window mid-test.** A controller that goes straight back to heating or testing without releasing the resource would keep hold_o high.
- **Heating that overshoots the upper bound.** A wrong priority order would route the core into test instead of cooling.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [2:0] {
    ST_DONE = 3'd0,
    ST_WAIT = 3'd1,
    ST_TEST = 3'd2,
    ST_HEAT = 3'd3,
    ST_COOL = 3'd4
  } twc_state_e;
endpackage

// File: rtl/twc_limits.sv
module twc_limits #(
  parameter int TW = 10,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] upper_i,
  input  logic [TW-1:0] lower_i,
  input  logic [TW-1:0] resume_i,
  input  logic [PW-1:0] thr_pwr_i,
  output logic [TW-1:0] upper_o,
  output logic [TW-1:0] lower_o,
  output logic [TW-1:0] resume_o,
  output logic [TW-1:0] mid_o,
  output logic [PW-1:0] thr_pwr_o
);
  localparam int SW = TW + 1;

  logic [SW-1:0] sum;
  assign sum = {1'b0, upper_i} + {1'b0, lower_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_o   <= '0;
      lower_o   <= '0;
      resume_o  <= '0;
      mid_o     <= '0;
      thr_pwr_o <= '0;
    end else if (load_i) begin
      upper_o   <= upper_i;
      lower_o   <= lower_i;
      resume_o  <= resume_i;
      mid_o     <= sum[SW-1:1];
      thr_pwr_o <= thr_pwr_i;
    end
  end

  AST_MID_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lower_o <= upper_o) |-> (mid_o >= lower_o && mid_o <= upper_o)); // R7
endmodule

// File: rtl/twc_compare.sv
module twc_compare #(
  parameter int TW = 10,
  parameter int PW = 8
) (
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] upper_i,
  input  logic [TW-1:0] lower_i,
  input  logic [TW-1:0] resume_i,
  input  logic [TW-1:0] mid_i,
  input  logic [PW-1:0] next_pwr_i,
  input  logic [PW-1:0] thr_pwr_i,
  output logic          above_upper_o,
  output logic          below_lower_o,
  output logic          below_resume_o,
  output logic          heat_done_o
);
  logic          hot_tests;
  logic [TW-1:0] heat_target;

  assign above_upper_o  = temp_i > upper_i;
  assign below_lower_o  = temp_i < lower_i;
  assign below_resume_o = temp_i < resume_i;
  // power-hungry tests warm the core themselves: stop heating at the lower bound
  assign hot_tests      = next_pwr_i > thr_pwr_i;
  assign heat_target    = hot_tests ? lower_i : mid_i;
  assign heat_done_o    = temp_i >= heat_target;
endmodule

// File: rtl/twc_fsm.sv
module twc_fsm
  import twc_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] count_i,
  input  logic          grant_i,
  input  logic          above_upper_i,
  input  logic          below_lower_i,
  input  logic          below_resume_i,
  input  logic          heat_done_i,
  output twc_state_e    state_o
);
  twc_state_e    state_q, state_d;
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    if (load_i) begin
      left_d  = count_i;
      state_d = (count_i == '0) ? ST_DONE : ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT: if (grant_i) begin
          if (above_upper_i)      state_d = ST_COOL;
          else if (below_lower_i) state_d = ST_HEAT;
          else                    state_d = ST_TEST;
        end
        ST_TEST: begin
          if (above_upper_i)      state_d = ST_COOL;
          else if (below_lower_i) state_d = ST_WAIT;
          else begin
            left_d = left_q - 1'b1;
            if (left_q == CW'(1)) state_d = ST_DONE;
          end
        end
        ST_HEAT: begin
          if (above_upper_i)    state_d = ST_COOL;
          else if (heat_done_i) state_d = ST_TEST;
        end
        ST_COOL: if (below_resume_i) state_d = ST_WAIT;
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DONE;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
    end
  end

  assign state_o = state_q;

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !grant_i && !load_i) |=> state_q == ST_WAIT); // R3
  AST_TEST_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TEST && above_upper_i && !load_i) |=> state_q == ST_COOL); // R4
  AST_TEST_COLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TEST && below_lower_i && !load_i) |=> state_q == ST_WAIT); // R5
  AST_HEAT_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HEAT && above_upper_i && !load_i) |=> state_q == ST_COOL); // R8
  AST_COOL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COOL && !below_resume_i && !load_i) |=> state_q == ST_COOL); // R9
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !load_i) |=> state_q == ST_DONE); // R10
  AST_TEST_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TEST) |-> left_q != '0); // R10
endmodule

// File: rtl/thermal_window_ctrl.sv
module thermal_window_ctrl
  import twc_pkg::*;
#(
  parameter int TW = 10,
  parameter int PW = 8,
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] upper_i,
  input  logic [TW-1:0] lower_i,
  input  logic [TW-1:0] resume_i,
  input  logic [PW-1:0] thr_pwr_i,
  input  logic [CW-1:0] count_i,
  input  logic [TW-1:0] temp_i,
  input  logic [PW-1:0] next_pwr_i,
  input  logic          grant_i,
  output logic [2:0]    state_o,
  output logic          req_o,
  output logic          hold_o
);
  logic [TW-1:0] upper_q, lower_q, resume_q, mid_q;
  logic [PW-1:0] thr_q;
  logic          above_upper, below_lower, below_resume, heat_done;
  twc_state_e    state;

  twc_limits #(.TW(TW), .PW(PW)) u_limits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .upper_i   (upper_i),
    .lower_i   (lower_i),
    .resume_i  (resume_i),
    .thr_pwr_i (thr_pwr_i),
    .upper_o   (upper_q),
    .lower_o   (lower_q),
    .resume_o  (resume_q),
    .mid_o     (mid_q),
    .thr_pwr_o (thr_q)
  );

  twc_compare #(.TW(TW), .PW(PW)) u_compare (
    .temp_i         (temp_i),
    .upper_i        (upper_q),
    .lower_i        (lower_q),
    .resume_i       (resume_q),
    .mid_i          (mid_q),
    .next_pwr_i     (next_pwr_i),
    .thr_pwr_i      (thr_q),
    .above_upper_o  (above_upper),
    .below_lower_o  (below_lower),
    .below_resume_o (below_resume),
    .heat_done_o    (heat_done)
  );

  twc_fsm #(.CW(CW)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_i         (load_i),
    .count_i        (count_i),
    .grant_i        (grant_i),
    .above_upper_i  (above_upper),
    .below_lower_i  (below_lower),
    .below_resume_i (below_resume),
    .heat_done_i    (heat_done),
    .state_o        (state)
  );

  assign state_o = state;
  assign req_o   = (state == ST_WAIT);
  assign hold_o  = (state == ST_TEST) || (state == ST_HEAT);

  AST_REQ_HOLD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && hold_o)); // R3
  AST_COOL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_COOL) |-> (!req_o && !hold_o)); // R9
endmodule

// File: tb/tb_thermal_window_ctrl.sv
module tb_thermal_window_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 10;
  localparam int PW = 8;
  localparam int CW = 12;
  localparam logic [2:0] S_DONE = 3'd0, S_WAIT = 3'd1, S_TEST = 3'd2,
                         S_HEAT = 3'd3, S_COOL = 3'd4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [TW-1:0] upper_i = '0, lower_i = '0, resume_i = '0, temp_i = '0;
  logic [PW-1:0] thr_pwr_i = '0, next_pwr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          grant_i = 1'b0;
  logic [2:0]    state_o;
  logic          req_o, hold_o;

  int checks = 0;
  int errors = 0;

  int m_up, m_lo, m_rs, m_mid, m_thr, m_cnt;
  logic [2:0] ms = S_DONE;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_window_ctrl #(.TW(TW), .PW(PW), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .upper_i(upper_i),
    .lower_i(lower_i), .resume_i(resume_i), .thr_pwr_i(thr_pwr_i),
    .count_i(count_i), .temp_i(temp_i), .next_pwr_i(next_pwr_i),
    .grant_i(grant_i), .state_o(state_o), .req_o(req_o), .hold_o(hold_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_limits(input int up, input int lo, input int rs, input int thr);
    upper_i = up[TW-1:0]; lower_i = lo[TW-1:0];
    resume_i = rs[TW-1:0]; thr_pwr_i = thr[PW-1:0];
  endtask

  // drive one cycle, advance the model, check at the following negedge
  task automatic step(input bit ld, input int cnt, input bit gnt, input int t, input int np);
    string tg;
    load_i = ld; count_i = cnt[CW-1:0]; grant_i = gnt;
    temp_i = t[TW-1:0]; next_pwr_i = np[PW-1:0];
    if (ld) begin
      tg = "R2";
      m_up = int'(upper_i); m_lo = int'(lower_i); m_rs = int'(resume_i);
      m_thr = int'(thr_pwr_i); m_mid = (m_up + m_lo) >> 1; m_cnt = cnt;
      ms = (cnt == 0) ? S_DONE : S_WAIT;
    end else begin
      case (ms)
        S_WAIT: begin
          tg = "R3";
          if (gnt) ms = (t > m_up) ? S_COOL : (t < m_lo) ? S_HEAT : S_TEST;
        end
        S_TEST: begin
          if (t > m_up) begin tg = "R4"; ms = S_COOL; end
          else if (t < m_lo) begin tg = "R5"; ms = S_WAIT; end
          else begin
            tg = "R10"; m_cnt--;
            if (m_cnt == 0) ms = S_DONE;
          end
        end
        S_HEAT: begin
          if (t > m_up) begin tg = "R8"; ms = S_COOL; end
          else if (np > m_thr) begin tg = "R6"; if (t >= m_lo) ms = S_TEST; end
          else begin tg = "R7"; if (t >= m_mid) ms = S_TEST; end
        end
        S_COOL: begin tg = "R9"; if (t < m_rs) ms = S_WAIT; end
        default: tg = "R10";
      endcase
    end
    @(negedge clk);
    chk(state_o == ms, {tg, " state"}, int'(state_o), int'(ms));
    chk(req_o == (ms == S_WAIT), {tg, " req"}, int'(req_o), int'(ms == S_WAIT));
    chk(hold_o == (ms == S_TEST || ms == S_HEAT), {tg, " hold"}, int'(hold_o),
        int'(ms == S_TEST || ms == S_HEAT));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk(state_o == S_DONE && !req_o && !hold_o, "R1 reset", int'(state_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(state_o == S_DONE && !req_o && !hold_o, "R1 after release", int'(state_o), 0);

    // low-power heating goes to midpoint 500
    set_limits(700, 300, 500, 100);
    step(1, 3, 0, 400, 0);
    step(0, 0, 0, 250, 50);      // R3 no grant
    step(0, 0, 1, 250, 50);      // to HEAT
    step(0, 0, 0, 320, 50);      // R7 stays
    step(0, 0, 0, 499, 100);     // R7 equality of power keeps mid target
    step(0, 0, 0, 500, 50);      // R7 to TEST
    step(0, 0, 0, 550, 0);       // R10 count 3->2
    step(0, 0, 0, 710, 0);       // R4 to COOL
    step(0, 0, 1, 600, 0);       // R9 stays
    step(0, 0, 0, 500, 0);       // R9 at resume: stays
    step(0, 0, 0, 499, 0);       // R9 to WAIT
    // high-power heating stops at lower bound
    step(0, 0, 1, 280, 0);
    step(0, 0, 0, 299, 200);     // R6 stays
    step(0, 0, 0, 300, 101);     // R6 to TEST
    step(0, 0, 0, 290, 0);       // R5 to WAIT
    step(0, 0, 1, 250, 0);
    step(0, 0, 0, 720, 0);       // R8 overshoot
    step(0, 0, 0, 100, 0);
    step(0, 0, 1, 700, 0);       // R3 straight to TEST at upper bound
    step(0, 0, 0, 700, 0);       // R10 count 2->1
    step(0, 0, 0, 400, 0);       // R10 last -> DONE
    step(0, 0, 1, 400, 0);       // R10 grant ignored
    step(1, 0, 1, 400, 0);       // R2 zero count -> DONE
    step(0, 0, 1, 400, 0);
    // midpoint near range top
    set_limits(1023, 1021, 1022, 50);
    step(1, 2, 0, 900, 0);
    step(0, 0, 1, 1000, 0);
    step(0, 0, 0, 1021, 0);      // R7 mid 1022
    step(0, 0, 0, 1022, 0);      // R7 to TEST
    set_limits(700, 300, 500, 100);
    step(1, 5, 0, 1022, 0);      // R2 override during TEST

    t = 400;
    for (int i = 0; i < 4000; i++) begin
      bit ld;
      t = t + int'($urandom_range(0, 40)) - 20;
      if (t < 100) t = 100;
      if (t > 900) t = 900;
      ld = ($urandom_range(0, 199) == 0);
      if (ld) begin
        int lo, up;
        lo = int'($urandom_range(200, 400));
        up = lo + int'($urandom_range(100, 400));
        set_limits(up, lo, int'($urandom_range(lo, up)), int'($urandom_range(0, 255)));
      end
      step(ld, int'($urandom_range(0, 40)), bit'($urandom_range(0, 1)), t,
           int'($urandom_range(0, 255)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule